// File: doc/BRIEF.md
# Chainable Serial Gain Control Port

This block is the digital control side of a two-channel volume control. A host shifts 16-bit gain words in over a three-wire serial link (serial clock, active-low chip select, data in). The serial data out pin repeats each bit exactly one word later. Several devices can therefore be wired output-to-input and loaded together with a single long chip-select window. No device needs an address. When chip select returns high, the word held in the shift register becomes the pending setting. Its upper byte is the left gain and its lower byte is the right gain.

Each channel moves its pending byte onto its active gain output only when that channel's own zero-crossing strobe arrives. This keeps steps in the audio path inaudible. If no crossing arrives within a programmable number of system clock cycles, the pending gain is applied anyway. An active-low mute input clears all state and forces both gains to zero, which is the muted code. The serial clock, chip select, data and zero-crossing strobes are asynchronous. Each passes through a two-flop synchroniser into the system clock domain, and edges are detected after synchronisation. The system clock must therefore run several times faster than the serial clock. Mute is sampled synchronously.

Top module: `serial_volume_port`

## Requirements
- R1: After reset both gain outputs are 0, both pending flags are 0 and the data-out enable is 0.
- R2: On each synchronised rising serial clock edge while chip select is low, the shift register takes the data-in bit at its least significant end. Data out is the most significant bit, so each bit reappears on data out 16 edges after it entered, and a 32-edge window loads two chained devices.
- R3: The data-out enable is 1 while the synchronised chip select is low and 0 while it is high.
- R4: On a synchronised rising edge of chip select, the shift register is copied to the pending word (bits 15:8 left, bits 7:0 right) and both pending flags are set, without changing the gain outputs.
- R5: A synchronised rising edge of a channel's zero-crossing strobe moves that channel's pending byte to its gain output and clears its pending flag. The other channel is unaffected.
- R6: A channel still pending ZC_TIMEOUT cycles after the latch takes its pending byte and clears its flag without a zero crossing.
- R7: A zero-crossing strobe on a channel with no pending update leaves that channel's gain unchanged.
- R8: While mute_n is 0, both gains and pending flags are 0 and the shift register is cleared. Serial shifts and chip-select latches are ignored, so data out reads 0 after mute is released.
- R9: Serial clock edges while chip select is high do not change the shift register.
- R10: A latch while an update is still pending replaces the pending word and restarts that channel's timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_n | input | 1 | Synchronous active-low mute and clear |
| sclk | input | 1 | Serial clock, asynchronous |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sdi | input | 1 | Serial data in |
| zc_l | input | 1 | Left zero-crossing strobe, asynchronous |
| zc_r | input | 1 | Right zero-crossing strobe, asynchronous |
| sdo | output | 1 | Serial data out toward the next device |
| sdo_oe | output | 1 | Output enable for the data-out pad driver |
| gain_l | output | GAIN_W | Active left gain, 0 is muted |
| gain_r | output | GAIN_W | Active right gain, 0 is muted |
| pend_l | output | 1 | Left update waiting for a zero crossing |
| pend_r | output | 1 | Right update waiting for a zero crossing |

## Verification
The bench loads a single asymmetric word (0xA55A), which would expose swapped byte lanes or reversed bit order. A 32-bit chained window shows that only the last word is kept, while data out replays the first word one word late. A zero crossing on one channel only, a long wait without crossings, and a crossing with nothing pending separate the gated update from the timeout and from spurious updates. Three further patterns cover corner cases: serial clock pulses with chip select high, a second latch over a pending update, and mute asserted mid-update with writes attempted during mute. A behavioural model compares every output on every clock.

// File: rtl/serial_volume_port.sv
module serial_volume_port #(
  parameter int GAIN_W     = 8,
  parameter int ZC_TIMEOUT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              zc_l,
  input  logic              zc_r,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [GAIN_W-1:0] gain_l,
  output logic [GAIN_W-1:0] gain_r,
  output logic              pend_l,
  output logic              pend_r
);
  localparam int WORD_W = 2 * GAIN_W;
  localparam int CNT_W  = $clog2(ZC_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ZC_TIMEOUT - 1);

  logic [2:0] sclk_p, cs_p, zl_p, zr_p;
  logic [1:0] sdi_p;
  logic [WORD_W-1:0] sr, pend_word;
  logic [GAIN_W-1:0] gain_q [2];
  logic [CNT_W-1:0]  cnt_q  [2];
  logic [1:0]        pend_q;
  logic              sclk_rise, cs_rise, latch_ev;
  logic [1:0]        zc_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      zl_p   <= '0;
      zr_p   <= '0;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      zl_p   <= {zl_p[1:0], zc_l};
      zr_p   <= {zr_p[1:0], zc_r};
      sdi_p  <= {sdi_p[0], sdi};
    end
  end

  assign sclk_rise  = sclk_p[1] & ~sclk_p[2];
  assign cs_rise    = cs_p[1] & ~cs_p[2];
  assign latch_ev   = cs_rise & mute_n;
  assign zc_rise[1] = zl_p[1] & ~zl_p[2];
  assign zc_rise[0] = zr_p[1] & ~zr_p[2];

  assign sdo    = sr[WORD_W-1];
  assign sdo_oe = ~cs_p[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      pend_word <= '0;
    end else if (!mute_n) begin
      sr        <= '0;
      pend_word <= '0;
    end else begin
      if (sclk_rise && !cs_p[1]) sr <= {sr[WORD_W-2:0], sdi_p[1]};
      if (latch_ev) pend_word <= sr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int c = 0; c < 2; c++) begin
        gain_q[c] <= '0;
        cnt_q[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (!mute_n) begin
          gain_q[c] <= '0;
          cnt_q[c]  <= '0;
          pend_q[c] <= 1'b0;
        end else if (latch_ev) begin
          cnt_q[c]  <= '0;
          pend_q[c] <= 1'b1;
        end else if (pend_q[c]) begin
          if (zc_rise[c] || cnt_q[c] == CNT_LAST) begin
            gain_q[c] <= pend_word[c*GAIN_W +: GAIN_W];
            cnt_q[c]  <= '0;
            pend_q[c] <= 1'b0;
          end else begin
            cnt_q[c] <= cnt_q[c] + 1'b1;
          end
        end
      end
    end
  end

  assign gain_l = gain_q[1];
  assign gain_r = gain_q[0];
  assign pend_l = pend_q[1];
  assign pend_r = pend_q[0];

  assert_mute_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n |=> (gain_l == '0 && gain_r == '0 && !pend_l && !pend_r && !sdo));

  assert_left_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_n && !pend_l) |=> $stable(gain_l));

  assert_right_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_n && !pend_r) |=> $stable(gain_r));

  assert_latch_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ev |=> (pend_l && pend_r && pend_word == $past(sr) && $stable(gain_l) && $stable(gain_r)));

  assert_timeout_applies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_n && pend_l && cnt_q[1] == CNT_LAST && !latch_ev)
      |=> (!pend_l && gain_l == $past(pend_word[WORD_W-1:GAIN_W])));

  assert_idle_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_n && cs_p[1]) |=> $stable(sr));
endmodule

// File: tb/serial_volume_port_tb.sv
module serial_volume_port_tb_top;
  localparam int TO = 300;

  logic clk = 0, rst_n = 0, mute_n = 1, sclk = 0, cs_n = 1, sdi = 0, zc_l = 0, zc_r = 0;
  logic sdo, sdo_oe, pend_l, pend_r;
  logic [7:0] gain_l, gain_r;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_volume_port #(.GAIN_W(8), .ZC_TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .zc_l(zc_l), .zc_r(zc_r), .sdo(sdo), .sdo_oe(sdo_oe), .gain_l(gain_l),
    .gain_r(gain_r), .pend_l(pend_l), .pend_r(pend_r));

  // behavioural reference: delayed input histories, word and per-channel state
  bit h_sclk[$], h_cs[$], h_sdi[$], h_zl[$], h_zr[$];
  bit [15:0] m_sr, m_pw;
  int m_gain[2], m_cnt[2];
  bit m_pend[2];

  function automatic void hist_init();
    h_sclk = '{0, 0, 0}; h_cs = '{1, 1, 1}; h_sdi = '{0, 0, 0};
    h_zl = '{0, 0, 0}; h_zr = '{0, 0, 0};
  endfunction

  initial hist_init();

  always @(posedge clk) begin
    if (!rst_n) begin
      hist_init();
      m_sr = 0; m_pw = 0;
      for (int c = 0; c < 2; c++) begin m_gain[c] = 0; m_cnt[c] = 0; m_pend[c] = 0; end
    end else begin
      bit s_r, c_low, c_r;
      bit z_r[2];
      s_r = h_sclk[1] && !h_sclk[2];
      c_low = !h_cs[1];
      c_r = h_cs[1] && !h_cs[2];
      z_r[1] = h_zl[1] && !h_zl[2];
      z_r[0] = h_zr[1] && !h_zr[2];
      for (int c = 0; c < 2; c++) begin
        if (!mute_n) begin
          m_gain[c] = 0; m_cnt[c] = 0; m_pend[c] = 0;
        end else if (c_r) begin
          m_pend[c] = 1; m_cnt[c] = 0;
        end else if (m_pend[c]) begin
          if (z_r[c] || m_cnt[c] == TO - 1) begin
            m_gain[c] = (c == 1) ? int'(m_pw[15:8]) : int'(m_pw[7:0]);
            m_pend[c] = 0; m_cnt[c] = 0;
          end else m_cnt[c]++;
        end
      end
      if (!mute_n) begin
        m_sr = 0; m_pw = 0;
      end else begin
        if (c_r) m_pw = m_sr;
        if (s_r && c_low) m_sr = {m_sr[14:0], h_sdi[1]};
      end
      void'(h_sclk.pop_back()); h_sclk.push_front(sclk);
      void'(h_cs.pop_back());   h_cs.push_front(cs_n);
      void'(h_sdi.pop_back());  h_sdi.push_front(sdi);
      void'(h_zl.pop_back());   h_zl.push_front(zc_l);
      void'(h_zr.pop_back());   h_zr.push_front(zc_r);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("R2 sdo", int'(sdo), int'(m_sr[15]));
      chk("R3 sdo_oe", int'(sdo_oe), int'(!h_cs[1]));
      chk("R5 gain_l", int'(gain_l), m_gain[1]);
      chk("R5 gain_r", int'(gain_r), m_gain[0]);
      chk("R4 pend_l", int'(pend_l), int'(m_pend[1]));
      chk("R4 pend_r", int'(pend_r), int'(m_pend[0]));
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    sdi = b; wait_n(3);
    sclk = 1; wait_n(3);
    sclk = 0;
  endtask

  task automatic send_word(bit [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_zc(bit l, bit r);
    zc_l = l; zc_r = r; wait_n(3);
    zc_l = 0; zc_r = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait_n(150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    wait_n(5);
    rst_n = 1;
    wait_n(2);
    chk("R1 gain_l", int'(gain_l), 0);
    chk("R1 gain_r", int'(gain_r), 0);
    chk("R1 pend", int'({pend_l, pend_r}), 0);
    chk("R1 sdo_oe", int'(sdo_oe), 0);

    cs_n = 0; wait_n(4);
    chk("R3 enable low cs", int'(sdo_oe), 1);
    send_word(16'hA55A);
    cs_n = 1; wait_n(6);
    chk("R4 pending set", int'({pend_l, pend_r}), 3);
    chk("R4 gain unchanged", int'(gain_l), 0);
    chk("R3 enable high cs", int'(sdo_oe), 0);

    pulse_zc(1, 0); wait_n(5);
    chk("R5 left applied", int'(gain_l), 'hA5);
    chk("R5 right waits", int'(gain_r), 0);
    chk("R5 right pending", int'(pend_r), 1);

    wait_n(TO + 20);
    chk("R6 timeout applied", int'(gain_r), 'h5A);
    chk("R6 flag cleared", int'(pend_r), 0);

    pulse_zc(1, 1); wait_n(5);
    chk("R7 right unchanged", int'(gain_r), 'h5A);
    chk("R7 left unchanged", int'(gain_l), 'hA5);

    cs_n = 0; wait_n(4);
    send_word(16'hABCD);
    send_word(16'h1357);
    cs_n = 1; wait_n(6);
    pulse_zc(1, 1); wait_n(5);
    chk("R2 chain left", int'(gain_l), 'h13);
    chk("R2 chain right", int'(gain_r), 'h57);

    cs_n = 0; wait_n(4);
    send_word(16'h7FFF);
    cs_n = 1; wait_n(6);
    send_bit(1);
    wait_n(4);
    cs_n = 0; wait_n(6);
    chk("R9 no shift while deselected", int'(sdo), 0);

    send_word(16'h2244);
    cs_n = 1; wait_n(6);
    pulse_zc(1, 0); wait_n(5);
    chk("R10 newer word wins", int'(gain_l), 'h22);
    chk("R10 right still pending", int'(pend_r), 1);

    mute_n = 0; wait_n(3);
    chk("R8 gains zero", int'({gain_l, gain_r}), 0);
    chk("R8 pending cleared", int'({pend_l, pend_r}), 0);
    cs_n = 0; wait_n(4);
    send_word(16'hFFFF);
    cs_n = 1; wait_n(6);
    chk("R8 latch ignored", int'({pend_l, pend_r}), 0);
    chk("R8 gains still zero", int'({gain_l, gain_r}), 0);
    mute_n = 1; wait_n(2);
    cs_n = 0; wait_n(6);
    chk("R8 shift register cleared", int'(sdo), 0);
    cs_n = 1; wait_n(10);

    finish_run();
  end
endmodule